// File: doc/BRIEF.md
# Receive Buffer Ring Writer

This block takes received Ethernet frame bytes, one per cycle on a valid/last stream with no back-pressure, and scatters each frame over a ring of fixed 128-byte buffers in system memory. Each buffer is described by a two-word entry in a descriptor store that the block keeps locally. The first word is the address word. It holds the buffer base address, an ownership flag in bit 0 and an end-of-ring marker in bit 1. The second word is the status word, which the hardware fills in.

Software prepares the address words through a word-wide write port and reads the descriptors back through a combinational read port. It hands a buffer to the hardware by clearing the ownership flag. The hardware sets the flag again once the buffer has been filled and its status word written.

The block writes the data bytes through a byte-wide memory write port. It marks where frames start and end, records the frame length and the address-match side-band flags, and raises a sticky overrun flag when it runs out of buffers.

Top module: `rxring_writer`

## Requirements
- R1: After reset the block issues no memory write, `overrun` is 0, every descriptor word reads back as zero, and the hardware starts at descriptor 0.
- R2: Each accepted byte is written in the same cycle to memory at the buffer base plus its byte offset (0 to 127) inside the buffer. The buffer base is the address word with bits 1:0 cleared, captured when the buffer's first byte arrives.
- R3: A buffer is closed after its 128th byte or at a byte flagged last, whichever comes first. The next byte goes to the next descriptor, so a 300-byte frame fills three descriptors.
- R4: In the status word, bit 14 is set only for the first buffer of a frame and bit 15 only for the last. Bits 11:0 hold the total frame length (modulo 4096) in the last buffer and are zero in the other buffers. Every other status bit of a non-last buffer is zero.
- R5: The status word of a frame's last buffer carries the side-band flags sampled with the last byte: bit 31 = `inBcast`, bit 26-i = `inAddrMatch[i]` for i = 0 to 3, and bit 22 = `inTypeMatch`.
- R6: A buffer's status word is readable the cycle after its closing byte. Bit 0 of its address word becomes 1 one cycle later, and the other address bits are left unchanged.
- R7: After the descriptor whose address bit 1 is set, or after the last descriptor of the ring, the next buffer is taken from descriptor 0.
- R8: A byte that needs a new buffer is dropped if the address word of the current descriptor has bit 0 set. The remaining bytes of that frame up to its last byte are dropped too, and no descriptor is changed. `overrun` then stays at 1 until reset, and the next frame starts at the same descriptor with bit 14 set in its first buffer.
- R9: A software write stores one whole word (select 0 = address word, 1 = status word). If the hardware writes a status word in the same cycle, the hardware value wins. If software writes the address word in the same cycle that the hardware sets its bit 0, the stored word is the software data with bit 0 forced to 1.
- R10: A descriptor whose bit 0 software has cleared again is filled by the next frame that reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte present on `inData` |
| inData | input | 8 | Received byte |
| inLast | input | 1 | Byte is the last of its frame |
| inBcast | input | 1 | Broadcast destination flag, sampled with the last byte |
| inAddrMatch | input | 4 | Specific-address match flags 1..4 (bit 0 = match 1) |
| inTypeMatch | input | 1 | Type-ID match flag |
| swWrEn | input | 1 | Software descriptor write strobe |
| swWrSel | input | 1 | 0 = address word, 1 = status word |
| swWrIdx | input | IDX_W | Descriptor written by software |
| swWrData | input | 32 | Word written by software |
| swRdSel | input | 1 | 0 = address word, 1 = status word |
| swRdIdx | input | IDX_W | Descriptor read by software |
| swRdData | output | 32 | Selected descriptor word (combinational) |
| memWrEn | output | 1 | Buffer byte write strobe |
| memWrAddr | output | 32 | Byte address of the write |
| memWrData | output | 8 | Byte written |
| overrun | output | 1 | Sticky: a frame lost bytes for lack of a free buffer |

## Verification
Two of the block's actions can land in the same cycle. The hardware sets the ownership bit of the buffer it just closed, and software may rewrite that same address word in that cycle. Likewise, the hardware writes back a status word while software writes that same status word. The bench provokes both by closing a one-byte frame while a software write to the same status word is driven, and by writing the address word of that descriptor in the very next cycle. The reference model applies the priorities of R9 and is compared against the read-back port every cycle. Back-to-back single-byte frames keep the closing step and the ownership step of neighbouring descriptors overlapping across the ring.

// File: rtl/rxring_pkg.sv
`timescale 1ns/1ps
package rxring_pkg;

  localparam int DESC_W    = 32;
  localparam int LEN_W     = 12;
  localparam int BUF_BYTES = 128;
  localparam int OFF_W     = $clog2(BUF_BYTES);

  // address word flags
  localparam int OWN_BIT  = 0;
  localparam int LAST_BIT = 1;

  // status word fields
  localparam int SOF_BIT   = 14;
  localparam int EOF_BIT   = 15;
  localparam int TYPE_BIT  = 22;
  localparam int MATCH_TOP = 26;
  localparam int BCAST_BIT = 31;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_STAT = 1'b1
  } descSel_e;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic take;     // first byte of a fresh buffer
    logic wrByte;   // a byte is written to memory
    logic close;    // current buffer completes, write status
    logic eof;      // closing buffer ends the frame
    logic sof;      // closing buffer begins the frame
    logic setUsed;  // raise ownership bit of usedIdx
  } rxStrobe_t;

endpackage

// File: rtl/rxring_ctrl.sv
`timescale 1ns/1ps
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int NUM_DESC = 32,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             curUsed,
  input  logic             curWrap,
  output rxStrobe_t        strb,
  output logic [IDX_W-1:0] curIdx,
  output logic [IDX_W-1:0] usedIdx,
  output logic [OFF_W-1:0] byteOff,
  output logic [LEN_W-1:0] frameLen,
  output logic             overrun
);

  logic [IDX_W-1:0] idxQ;
  logic [OFF_W-1:0] offQ;
  logic [LEN_W-1:0] lenQ;
  logic             openQ;
  logic             dropQ;
  logic             sofQ;
  logic             pendQ;
  logic [IDX_W-1:0] pendIdxQ;
  logic             ovrQ;

  logic accept;
  logic ovrEvt;
  logic bufFull;
  logic closeNow;
  logic wrapNow;
  logic [LEN_W-1:0] lenNext;

  always_comb begin
    accept   = inValid && !dropQ && (openQ || !curUsed);
    ovrEvt   = inValid && !dropQ && !openQ && curUsed;
    bufFull  = (offQ == OFF_W'(BUF_BYTES - 1));
    closeNow = accept && (inLast || bufFull);
    wrapNow  = curWrap || (idxQ == IDX_W'(NUM_DESC - 1));
    lenNext  = lenQ + LEN_W'(1);
  end

  always_comb begin
    strb.take    = accept && !openQ;
    strb.wrByte  = accept;
    strb.close   = closeNow;
    strb.eof     = closeNow && inLast;
    strb.sof     = closeNow && sofQ;
    strb.setUsed = pendQ;
  end

  assign curIdx   = idxQ;
  assign usedIdx  = pendIdxQ;
  assign byteOff  = offQ;
  assign frameLen = lenNext;
  assign overrun  = ovrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      offQ     <= '0;
      lenQ     <= '0;
      openQ    <= 1'b0;
      dropQ    <= 1'b0;
      sofQ     <= 1'b1;
      pendQ    <= 1'b0;
      pendIdxQ <= '0;
      ovrQ     <= 1'b0;
    end else begin
      pendQ    <= closeNow;
      pendIdxQ <= idxQ;
      if (inValid) begin
        if (dropQ) begin
          if (inLast) begin
            dropQ <= 1'b0;
            sofQ  <= 1'b1;
            lenQ  <= '0;
          end
        end else if (ovrEvt) begin
          ovrQ <= 1'b1;
          if (inLast) begin
            sofQ <= 1'b1;
            lenQ <= '0;
          end else begin
            dropQ <= 1'b1;
          end
        end else begin
          lenQ <= inLast ? '0 : lenNext;
          if (closeNow) begin
            idxQ  <= wrapNow ? '0 : idxQ + IDX_W'(1);
            openQ <= 1'b0;
            offQ  <= '0;
            sofQ  <= inLast;
          end else begin
            openQ <= 1'b1;
            offQ  <= offQ + OFF_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/rxring_dpath.sv
`timescale 1ns/1ps
module rxring_dpath
  import rxring_pkg::*;
#(
  parameter int NUM_DESC = 32,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [IDX_W-1:0]  usedIdx,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [7:0]        inData,
  input  logic              inBcast,
  input  logic [3:0]        inAddrMatch,
  input  logic              inTypeMatch,
  input  logic              swWrEn,
  input  logic              swWrSel,
  input  logic [IDX_W-1:0]  swWrIdx,
  input  logic [DESC_W-1:0] swWrData,
  input  logic              swRdSel,
  input  logic [IDX_W-1:0]  swRdIdx,
  output logic [DESC_W-1:0] swRdData,
  output logic              curUsed,
  output logic              curWrap,
  output logic              memWrEn,
  output logic [DESC_W-1:0] memWrAddr,
  output logic [7:0]        memWrData
);

  logic [DESC_W-1:0] addrMem  [NUM_DESC];
  logic [DESC_W-1:0] statMem  [NUM_DESC];
  logic [DESC_W-1:0] addrNext [NUM_DESC];
  logic [DESC_W-1:0] statNext [NUM_DESC];

  logic [DESC_W-1:0] curAddr;
  logic [DESC_W-1:0] takeBase;
  logic [DESC_W-1:0] bufBase;
  logic [DESC_W-1:0] statWord;

  assign curAddr  = addrMem[curIdx];
  assign curUsed  = curAddr[OWN_BIT];
  assign curWrap  = curAddr[LAST_BIT];
  assign takeBase = {curAddr[DESC_W-1:2], 2'b00};

  // status word for the buffer being closed
  always_comb begin
    statWord          = '0;
    statWord[SOF_BIT] = strb.sof;
    if (strb.eof) begin
      statWord[EOF_BIT]     = 1'b1;
      statWord[LEN_W-1:0]   = frameLen;
      statWord[BCAST_BIT]   = inBcast;
      statWord[TYPE_BIT]    = inTypeMatch;
      for (int m = 0; m < 4; m++) begin
        statWord[MATCH_TOP - m] = inAddrMatch[m];
      end
    end
  end

  // next state of the descriptor store: software first, hardware on top
  always_comb begin
    for (int i = 0; i < NUM_DESC; i++) begin
      addrNext[i] = addrMem[i];
      statNext[i] = statMem[i];
      if (swWrEn && swWrIdx == IDX_W'(i)) begin
        if (swWrSel == SEL_STAT) statNext[i] = swWrData;
        else                     addrNext[i] = swWrData;
      end
      if (strb.setUsed && usedIdx == IDX_W'(i)) begin
        addrNext[i][OWN_BIT] = 1'b1;
      end
      if (strb.close && curIdx == IDX_W'(i)) begin
        statNext[i] = statWord;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        addrMem[i] <= '0;
        statMem[i] <= '0;
      end
      bufBase <= '0;
    end else begin
      for (int i = 0; i < NUM_DESC; i++) begin
        addrMem[i] <= addrNext[i];
        statMem[i] <= statNext[i];
      end
      if (strb.take) bufBase <= takeBase;
    end
  end

  always_comb begin
    if (swRdIdx < IDX_W'(NUM_DESC - 1) || swRdIdx == IDX_W'(NUM_DESC - 1)) begin
      swRdData = (swRdSel == SEL_STAT) ? statMem[swRdIdx] : addrMem[swRdIdx];
    end else begin
      swRdData = '0;
    end
  end

  assign memWrEn   = strb.wrByte;
  assign memWrAddr = (strb.take ? takeBase : bufBase) + DESC_W'(byteOff);
  assign memWrData = inData;

endmodule

// File: rtl/rxring_writer.sv
`timescale 1ns/1ps
module rxring_writer
  import rxring_pkg::*;
#(
  parameter  int NUM_DESC = 32,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  logic             inBcast,
  input  logic [3:0]       inAddrMatch,
  input  logic             inTypeMatch,
  input  logic             swWrEn,
  input  logic             swWrSel,
  input  logic [IDX_W-1:0] swWrIdx,
  input  logic [31:0]      swWrData,
  input  logic             swRdSel,
  input  logic [IDX_W-1:0] swRdIdx,
  output logic [31:0]      swRdData,
  output logic             memWrEn,
  output logic [31:0]      memWrAddr,
  output logic [7:0]       memWrData,
  output logic             overrun
);

  rxStrobe_t        strb;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] usedIdx;
  logic [OFF_W-1:0] byteOff;
  logic [LEN_W-1:0] frameLen;
  logic             curUsed;
  logic             curWrap;

  rxring_ctrl #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .curUsed  (curUsed),
    .curWrap  (curWrap),
    .strb     (strb),
    .curIdx   (curIdx),
    .usedIdx  (usedIdx),
    .byteOff  (byteOff),
    .frameLen (frameLen),
    .overrun  (overrun)
  );

  rxring_dpath #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .curIdx      (curIdx),
    .usedIdx     (usedIdx),
    .byteOff     (byteOff),
    .frameLen    (frameLen),
    .inData      (inData),
    .inBcast     (inBcast),
    .inAddrMatch (inAddrMatch),
    .inTypeMatch (inTypeMatch),
    .swWrEn      (swWrEn),
    .swWrSel     (swWrSel),
    .swWrIdx     (swWrIdx),
    .swWrData    (swWrData),
    .swRdSel     (swRdSel),
    .swRdIdx     (swRdIdx),
    .swRdData    (swRdData),
    .curUsed     (curUsed),
    .curWrap     (curWrap),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData)
  );

endmodule

// File: rtl/rxring_writer_chk.sv
`timescale 1ns/1ps
module rxring_writer_chk
  import rxring_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             memWrEn,
  input logic             overrun,
  input rxStrobe_t        strb,
  input logic [IDX_W-1:0] curIdx,
  input logic [IDX_W-1:0] usedIdx,
  input logic             curUsed
);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R6
  own_after_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.close |=> (strb.setUsed && usedIdx == $past(curIdx)));

  // R2
  write_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> inValid);

  // R7
  ring_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.close |=> (curIdx == '0 || curIdx == $past(curIdx) + IDX_W'(1)));

  // R8
  no_take_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> !curUsed);

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.close |=> $stable(curIdx));

endmodule

bind rxring_writer rxring_writer_chk #(.IDX_W(IDX_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .memWrEn (memWrEn),
  .overrun (overrun),
  .strb    (strb),
  .curIdx  (curIdx),
  .usedIdx (usedIdx),
  .curUsed (curUsed)
);

// File: tb/rxring_writer_tb_top.sv
`timescale 1ns/1ps
module rxring_writer_tb_top;

  localparam int ND = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic          inValid, inLast, inBcast, inTypeMatch;
  logic [7:0]    inData;
  logic [3:0]    inAddrMatch;
  logic          swWrEn, swWrSel, swRdSel;
  logic [IW-1:0] swWrIdx, swRdIdx;
  logic [31:0]   swWrData, swRdData, memWrAddr;
  logic          memWrEn, overrun;
  logic [7:0]    memWrData;

  rxring_writer #(.NUM_DESC(ND)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inBcast(inBcast), .inAddrMatch(inAddrMatch), .inTypeMatch(inTypeMatch),
    .swWrEn(swWrEn), .swWrSel(swWrSel), .swWrIdx(swWrIdx), .swWrData(swWrData),
    .swRdSel(swRdSel), .swRdIdx(swRdIdx), .swRdData(swRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData), .overrun(overrun)
  );

  int compared = 0;
  int mismatched = 0;

  // reference model state
  logic [31:0] mAddr [ND];
  logic [31:0] mStat [ND];
  logic [31:0] mBase;
  int mIdx, mOff, mLen, mPendIdx;
  bit mOpen, mDrop, mSof, mPend, mOvr;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL R1 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare this cycle, then advance the model across the clock edge
  task automatic tick();
    logic [31:0] nA [ND];
    logic [31:0] nS [ND];
    logic [31:0] eAddr, eRd, st;
    bit acc, ovrEvt, nPend;
    int nPendIdx, len;
    #2;
    acc = 0; ovrEvt = 0; eAddr = 0;
    if (inValid && !mDrop) begin
      if (!mOpen && mAddr[mIdx][0]) ovrEvt = 1;
      else begin
        acc = 1;
        eAddr = (mOpen ? mBase : {mAddr[mIdx][31:2], 2'b00}) + 32'(mOff);
      end
    end
    chk("R2", "memWrEn", 32'(memWrEn), 32'(acc));
    if (acc) begin
      chk("R2", "memWrAddr", memWrAddr, eAddr);
      chk("R2", "memWrData", 32'(memWrData), 32'(inData));
    end
    chk("R8", "overrun", 32'(overrun), 32'(mOvr));
    eRd = swRdSel ? mStat[swRdIdx] : mAddr[swRdIdx];
    chk("R6", "swRdData", swRdData, eRd);

    nA = mAddr; nS = mStat;
    nPend = 0; nPendIdx = 0;
    if (swWrEn) begin
      if (swWrSel) nS[swWrIdx] = swWrData;
      else         nA[swWrIdx] = swWrData;
    end
    if (mPend) nA[mPendIdx][0] = 1'b1;
    if (inValid) begin
      if (mDrop) begin
        if (inLast) begin mDrop = 0; mSof = 1; mLen = 0; end
      end else if (ovrEvt) begin
        mOvr = 1;
        if (inLast) begin mSof = 1; mLen = 0; end
        else mDrop = 1;
      end else begin
        len = (mLen + 1) & 32'hFFF;
        if (!mOpen) mBase = {mAddr[mIdx][31:2], 2'b00};
        if (inLast || mOff == 127) begin
          st = 0;
          if (mSof) st[14] = 1'b1;
          if (inLast) begin
            st[15] = 1'b1;
            st[11:0] = len[11:0];
            st[31] = inBcast;
            st[26] = inAddrMatch[0];
            st[25] = inAddrMatch[1];
            st[24] = inAddrMatch[2];
            st[23] = inAddrMatch[3];
            st[22] = inTypeMatch;
          end
          nS[mIdx] = st;
          nPend = 1; nPendIdx = mIdx;
          if (mAddr[mIdx][1] || mIdx == ND - 1) mIdx = 0;
          else mIdx = mIdx + 1;
          mOpen = 0; mOff = 0; mSof = inLast;
        end else begin
          mOpen = 1; mOff = mOff + 1;
        end
        mLen = inLast ? 0 : len;
      end
    end
    mAddr = nA; mStat = nS; mPend = nPend; mPendIdx = nPendIdx;
    @(negedge clk);
  endtask

  task automatic idle();
    inValid = 0; inLast = 0; swWrEn = 0;
    tick();
  endtask

  task automatic swWrite(int idx, bit sel, logic [31:0] data);
    swWrEn = 1; swWrIdx = IW'(idx); swWrSel = sel; swWrData = data;
    inValid = 0; inLast = 0;
    tick();
    swWrEn = 0;
  endtask

  task automatic checkDesc(int idx, bit sel, logic [31:0] exp, string tag);
    inValid = 0; inLast = 0; swWrEn = 0;
    swRdIdx = IW'(idx); swRdSel = sel;
    #1;
    chk(tag, sel ? "status word" : "address word", swRdData, exp);
    tick();
  endtask

  task automatic sendFrame(int n, bit bc, logic [3:0] am, bit tm, int gap);
    inBcast = bc; inAddrMatch = am; inTypeMatch = tm;
    for (int k = 0; k < n; k++) begin
      inValid = 1; inLast = (k == n - 1); inData = 8'(k) ^ 8'h5A;
      swRdIdx = IW'(k % ND); swRdSel = k[0];
      tick();
      if (gap > 0 && (k % gap) == gap - 1 && k != n - 1) idle();
    end
    inValid = 0; inLast = 0;
  endtask

  initial begin
    rstN = 0; inValid = 0; inLast = 0; inData = 0; inBcast = 0; inAddrMatch = 0;
    inTypeMatch = 0; swWrEn = 0; swWrSel = 0; swWrIdx = 0; swWrData = 0;
    swRdSel = 0; swRdIdx = 0;
    for (int i = 0; i < ND; i++) begin mAddr[i] = 0; mStat[i] = 0; end
    mBase = 0; mIdx = 0; mOff = 0; mLen = 0; mPendIdx = 0;
    mOpen = 0; mDrop = 0; mSof = 1; mPend = 0; mOvr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    #1;
    chk("R1", "memWrEn after reset", 32'(memWrEn), 32'd0);
    chk("R1", "overrun after reset", 32'(overrun), 32'd0);
    checkDesc(0, 0, 32'h0, "R1");
    checkDesc(3, 1, 32'h0, "R1");

    // software prepares buffers; descriptor 5 marks end of ring
    for (int i = 0; i < ND; i++) swWrite(i, 0, 32'h1000 + 32'(i) * 32'h80 + ((i == 5) ? 32'h2 : 32'h0));

    // R3/R4/R5: 300-byte broadcast frame with idle gaps
    sendFrame(300, 1, 4'b0000, 0, 37);
    idle(); idle();
    checkDesc(0, 1, 32'h0000_4000, "R4");
    checkDesc(1, 1, 32'h0000_0000, "R4");
    checkDesc(2, 1, 32'h8000_812C, "R5");
    checkDesc(1, 0, 32'h0000_1081, "R3");
    checkDesc(2, 0, 32'h0000_1101, "R6");

    // R5: exactly one buffer, match flags 1 and 3, type match
    sendFrame(128, 0, 4'b0101, 1, 0);
    idle(); idle();
    checkDesc(3, 1, 32'h0540_C080, "R5");

    // R9: one-byte frame closes while software writes the same status word,
    // then software rewrites the address word as ownership is set
    inBcast = 0; inAddrMatch = 0; inTypeMatch = 0;
    inValid = 1; inLast = 1; inData = 8'hC3;
    swWrEn = 1; swWrSel = 1; swWrIdx = 3'd4; swWrData = 32'hDEAD_BEEF;
    tick();
    inValid = 0; inLast = 0;
    swWrEn = 1; swWrSel = 0; swWrIdx = 3'd4; swWrData = 32'h0000_1200;
    tick();
    swWrEn = 0;
    checkDesc(4, 1, 32'h0000_C001, "R9");
    checkDesc(4, 0, 32'h0000_1201, "R9");

    // R7/R8: 200 bytes; descriptor 5 wraps to 0, which is still owned
    sendFrame(200, 0, 4'b0000, 0, 0);
    idle(); idle();
    checkDesc(5, 1, 32'h0000_4000, "R7");
    checkDesc(5, 0, 32'h0000_1283, "R7");
    checkDesc(6, 1, 32'h0000_0000, "R7");
    #1 chk("R8", "overrun after lost frame", 32'(overrun), 32'd1);
    idle();

    // R10: hand back 0..2 and receive again at descriptor 0
    for (int i = 0; i < 3; i++) swWrite(i, 0, 32'h1000 + 32'(i) * 32'h80);
    sendFrame(50, 0, 4'b0000, 0, 0);
    idle(); idle();
    checkDesc(0, 1, 32'h0000_C032, "R10");
    checkDesc(0, 0, 32'h0000_1001, "R10");

    // R7 by ring size: release 1..7 without end marker, send single-byte frames
    for (int i = 1; i < ND; i++) swWrite(i, 0, 32'h1000 + 32'(i) * 32'h80);
    for (int f = 0; f < ND; f++) sendFrame(1, 0, 4'b1000, 0, 0);
    idle(); idle();
    checkDesc(7, 1, 32'h0080_C001, "R7");
    checkDesc(0, 1, 32'h0000_C032, "R8");
    swWrite(0, 0, 32'h1000);
    sendFrame(1, 1, 4'b0000, 1, 0);
    idle(); idle();
    checkDesc(0, 1, 32'h8040_C001, "R7");
    checkDesc(0, 0, 32'h0000_1001, "R6");

    repeat (4) idle();
    summary();
    $finish;
  end

endmodule